// File: doc/BRIEF.md
# Timer Output Compare and PWM Unit

This block drives one output pin from the count of an external free-running timer. The timers are outside the block. Each arrives as a 16-bit count plus a one-cycle strobe that marks the end of its period. A control register picks the timer, the compare width and one of eight behaviours: off, one-way edge set, one-way edge clear, toggle, single pulse, repeating pulse, plain PWM, and PWM guarded by a fault input. Two data registers, primary and secondary, hold the compare values.

Software reaches the three registers over a small word-addressed bus. Each register owns four consecutive word addresses. The first replaces the value. The other three clear, set or invert only those bits that are 1 in the written word, so one write can change a bit without a read-modify-write. The unit also honours two pause requests, one from a debug halt and one from an idle request. Each pause works only if its enable bit is set.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, the control, primary and secondary registers read 0, `cmp_out` is 0 and the fault flag is 0.
- R2: The word address is `bus_addr`. Bits [3:2] select the register: 0 is control, 1 is primary, 2 is secondary, 3 is unmapped. Bits [1:0] select the write operation: 0 replaces the value, 1 clears the bits written as 1, 2 sets them, 3 inverts them. Only these control bits are writable: [2:0] mode, 3 timer select, 5 wide, 13 idle-stop, 14 debug-freeze and 15 enable. Mask 0xE02F covers them. Bit 4 cannot be written.
- R3: A read returns the register only at operation 0 of control, primary or secondary. Reads at operations 1 to 3, and reads of the unmapped group, return 0. At control, the fault flag reads back in bit 4.
- R4: Any write to the control group re-arms the output on the next edge. The output starts high only in mode 2 with enable set, and low in every other case. In mode 1 a primary match drives the output high. In mode 2 a primary match drives it low. In mode 3 every primary match inverts it.
- R5: In mode 4 the output goes high on a primary match and returns low on a following secondary match. After that it stays low until the next control write.
- R6: Mode 5 behaves like mode 4 but re-arms after each pulse, so every later primary match starts a new pulse.
- R7: In modes 6 and 7, each period strobe of the selected timer drives the output high and copies the secondary value into the primary register. A primary match drives the output low. The strobe takes priority over a match in the same cycle.
- R8: In mode 7, `fault_n` low forces the output low and sets the fault flag. Both hold until the next control write, which clears the flag.
- R9: In mode 6, `fault_n` has no effect on the output or the flag, and the flag is only ever set in mode 7.
- R10: With enable clear, the output is low and matches are ignored. Mode 0 keeps the output low even when enable is set.
- R11: Timer select 0 compares against timer A and 1 against timer B, using the low 16 bits of the data registers. With wide set, the count is {B, A} as 32 bits, the compare uses all 32 bits and the period strobe is B's.
- R12: While debug-freeze is set and `dbg_halt` is high, or idle-stop is set and `idle_req` is high, the output holds and matches have no effect. Without the enabling bit, the request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address: [3:2] register, [1:0] write operation |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tmr_a_count | input | 16 | Count of timer A |
| tmr_a_period | input | 1 | End-of-period strobe of timer A |
| tmr_b_count | input | 16 | Count of timer B |
| tmr_b_period | input | 1 | End-of-period strobe of timer B |
| dbg_halt | input | 1 | Debug halt request |
| idle_req | input | 1 | Idle request |
| fault_n | input | 1 | Active-low fault input for mode 7 |
| cmp_out | output | 1 | Registered compare output pin |

## Verification
The assertions assume that counts, strobes, `fault_n` and the pause requests are synchronous to `clk` and settled at each rising edge. They also assume that a control write is the only event that clears the fault latch. The properties about holding and off-state therefore exclude cycles that carry a control write or an active fault. The stimulus changes every input on the falling edge and holds each compare value for exactly one cycle. Between events it parks both timers at a count no register holds, so a toggle or pulse mode never sees a match the test did not intend.

// File: rtl/ocmp_pkg.sv
`timescale 1ns/1ps
package ocmp_pkg;

    localparam int TMR_W   = 16;
    localparam int REG_W   = 2 * TMR_W;
    localparam int CTRL_W  = 16;
    localparam int WADDR_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'hE02F;

    typedef enum logic [2:0] {
        MD_OFF       = 3'd0,
        MD_RISE      = 3'd1,
        MD_FALL      = 3'd2,
        MD_TOGGLE    = 3'd3,
        MD_ONESHOT   = 3'd4,
        MD_REPEAT    = 3'd5,
        MD_PWM       = 3'd6,
        MD_PWM_GUARD = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SET   = 2'd2,
        OP_FLIP  = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_PRI  = 2'd1,
        GRP_SEC  = 2'd2,
        GRP_NONE = 2'd3
    } reg_grp_e;

    typedef struct packed {
        logic       enable;
        logic       dbg_freeze;
        logic       idle_stop;
        logic [6:0] rsvd;
        logic       wide;
        logic       flt_ro;
        logic       tsel;
        mode_e      mode;
    } ctrl_t;

    function automatic logic [REG_W-1:0] alias_apply(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] val,
        input alias_op_e        op
    );
        case (op)
            OP_WRITE: return val;
            OP_CLEAR: return cur & ~val;
            OP_SET:   return cur | val;
            default:  return cur ^ val;
        endcase
    endfunction

    function automatic ctrl_t ctrl_apply(
        input ctrl_t             cur,
        input logic [CTRL_W-1:0] val,
        input alias_op_e         op
    );
        logic [CTRL_W-1:0] c;
        logic [CTRL_W-1:0] n;
        c = cur;
        case (op)
            OP_WRITE: n = val;
            OP_CLEAR: n = c & ~val;
            OP_SET:   n = c | val;
            default:  n = c ^ val;
        endcase
        return ctrl_t'(n & CTRL_WMASK);
    endfunction

    function automatic logic start_level(input ctrl_t c);
        return c.enable && (c.mode == MD_FALL);
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
`timescale 1ns/1ps
module ocmp_regs
    import ocmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic               reload,
    output ctrl_t              ctrl_q,
    output logic               ctrl_wr,
    output logic               init_lvl,
    output logic [REG_W-1:0]   pri_q,
    output logic [REG_W-1:0]   sec_q
);

    localparam int NDATA = 2;

    reg_grp_e  grp;
    alias_op_e op;
    ctrl_t     ctrl_d;
    logic [REG_W-1:0] data_q [NDATA];

    assign grp = reg_grp_e'(addr[WADDR_W-1:2]);
    assign op  = alias_op_e'(addr[1:0]);

    assign ctrl_wr  = wr_en && (grp == GRP_CTRL);
    assign ctrl_d   = ctrl_wr ? ctrl_apply(ctrl_q, wdata[CTRL_W-1:0], op) : ctrl_q;
    assign init_lvl = start_level(ctrl_d);

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    // Index 0 is the primary register and reloads from the secondary
    // register on a PWM period strobe. A bus write in the same cycle wins.
    for (genvar g = 0; g < NDATA; g++) begin : g_data
        localparam reg_grp_e MY_GRP = (g == 0) ? GRP_PRI : GRP_SEC;
        localparam logic     CAN_RELOAD = (g == 0);
        always_ff @(posedge clk) begin
            if (rst)
                data_q[g] <= '0;
            else if (wr_en && grp == MY_GRP)
                data_q[g] <= alias_apply(data_q[g], wdata, op);
            else if (CAN_RELOAD && reload)
                data_q[g] <= data_q[NDATA-1];
        end
    end

    assign pri_q = data_q[0];
    assign sec_q = data_q[1];

endmodule

// File: rtl/ocmp_tsel.sv
`timescale 1ns/1ps
module ocmp_tsel
    import ocmp_pkg::*;
(
    input  logic [TMR_W-1:0] a_count,
    input  logic             a_period,
    input  logic [TMR_W-1:0] b_count,
    input  logic             b_period,
    input  logic             tsel,
    input  logic             wide,
    input  logic [REG_W-1:0] pri,
    input  logic [REG_W-1:0] sec,
    output logic             hit_pri,
    output logic             hit_sec,
    output logic             period
);

    logic [TMR_W-1:0] narrow;
    logic [REG_W-1:0] joined;

    assign narrow = tsel ? b_count : a_count;
    assign joined = {b_count, a_count};

    always_comb begin
        if (wide) begin
            hit_pri = (joined == pri);
            hit_sec = (joined == sec);
            period  = b_period;
        end else begin
            hit_pri = (narrow == pri[TMR_W-1:0]);
            hit_sec = (narrow == sec[TMR_W-1:0]);
            period  = tsel ? b_period : a_period;
        end
    end

endmodule

// File: rtl/ocmp_wave.sv
`timescale 1ns/1ps
module ocmp_wave
    import ocmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  on,
    input  logic  run,
    input  logic  ctrl_wr,
    input  logic  init_lvl,
    input  logic  hit_pri,
    input  logic  hit_sec,
    input  logic  period,
    input  logic  fault_n,
    output logic  out,
    output logic  flag,
    output logic  reload
);

    logic out_q;
    logic done_q;
    logic flag_q;
    logic is_pwm;
    logic trip;

    assign is_pwm = (mode == MD_PWM) || (mode == MD_PWM_GUARD);
    assign trip   = on && (mode == MD_PWM_GUARD) && !fault_n;
    assign reload = run && is_pwm && period && !ctrl_wr && !flag_q && !trip;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= 1'b0;
            done_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (ctrl_wr) begin
            out_q  <= init_lvl;
            done_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (!on) begin
            out_q <= 1'b0;
        end else if (trip) begin
            out_q  <= 1'b0;
            flag_q <= 1'b1;
        end else if (flag_q) begin
            out_q <= 1'b0;
        end else if (run) begin
            case (mode)
                MD_RISE:   if (hit_pri) out_q <= 1'b1;
                MD_FALL:   if (hit_pri) out_q <= 1'b0;
                MD_TOGGLE: if (hit_pri) out_q <= ~out_q;
                MD_ONESHOT, MD_REPEAT: begin
                    if (!done_q) begin
                        if (hit_pri) begin
                            out_q <= 1'b1;
                        end else if (hit_sec && out_q) begin
                            out_q  <= 1'b0;
                            done_q <= (mode == MD_ONESHOT);
                        end
                    end
                end
                MD_PWM, MD_PWM_GUARD: begin
                    if (period)       out_q <= 1'b1;
                    else if (hit_pri) out_q <= 1'b0;
                end
                default: out_q <= 1'b0;
            endcase
        end
    end

    assign out  = out_q;
    assign flag = flag_q;

endmodule

// File: rtl/ocmp_unit.sv
`timescale 1ns/1ps
module ocmp_unit
    import ocmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [TMR_W-1:0]   tmr_a_count,
    input  logic               tmr_a_period,
    input  logic [TMR_W-1:0]   tmr_b_count,
    input  logic               tmr_b_period,
    input  logic               dbg_halt,
    input  logic               idle_req,
    input  logic               fault_n,
    output logic               cmp_out
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_rd;
    logic             ctrl_wr;
    logic             init_lvl;
    logic [REG_W-1:0] pri_q;
    logic [REG_W-1:0] sec_q;
    logic             hit_pri;
    logic             hit_sec;
    logic             period;
    logic             reload;
    logic             fault_flag;
    logic             unit_on;
    logic             hold;
    logic             run;
    logic             guard_mode;

    assign unit_on    = ctrl_q.enable;
    assign hold       = unit_on && ((ctrl_q.dbg_freeze && dbg_halt) ||
                                    (ctrl_q.idle_stop && idle_req));
    assign run        = unit_on && !hold;
    assign guard_mode = (ctrl_q.mode == MD_PWM_GUARD);

    ocmp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .reload   (reload),
        .ctrl_q   (ctrl_q),
        .ctrl_wr  (ctrl_wr),
        .init_lvl (init_lvl),
        .pri_q    (pri_q),
        .sec_q    (sec_q)
    );

    ocmp_tsel u_tsel (
        .a_count  (tmr_a_count),
        .a_period (tmr_a_period),
        .b_count  (tmr_b_count),
        .b_period (tmr_b_period),
        .tsel     (ctrl_q.tsel),
        .wide     (ctrl_q.wide),
        .pri      (pri_q),
        .sec      (sec_q),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .period   (period)
    );

    ocmp_wave u_wave (
        .clk      (clk),
        .rst      (rst),
        .mode     (ctrl_q.mode),
        .on       (unit_on),
        .run      (run),
        .ctrl_wr  (ctrl_wr),
        .init_lvl (init_lvl),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .period   (period),
        .fault_n  (fault_n),
        .out      (cmp_out),
        .flag     (fault_flag),
        .reload   (reload)
    );

    always_comb begin
        ctrl_rd        = ctrl_q;
        ctrl_rd.flt_ro = fault_flag;
        bus_rdata      = '0;
        if (alias_op_e'(bus_addr[1:0]) == OP_WRITE) begin
            case (reg_grp_e'(bus_addr[WADDR_W-1:2]))
                GRP_CTRL: bus_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_rd};
                GRP_PRI:  bus_rdata = pri_q;
                GRP_SEC:  bus_rdata = sec_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ocmp_unit_chk.sv
`timescale 1ns/1ps
module ocmp_unit_chk
    import ocmp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               unit_on,
    input logic               hold,
    input logic               guard_mode,
    input logic               ctrl_wr,
    input logic               fault_n,
    input logic               cmp_out,
    input logic               fault_flag,
    input logic [WADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]   bus_rdata
);

    assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
        (!unit_on && !ctrl_wr) |=> !cmp_out);

    assert_fault_forces_low_R8: assert property (@(posedge clk) disable iff (rst)
        (guard_mode && unit_on && !fault_n && !ctrl_wr) |=> (!cmp_out && fault_flag));

    assert_flag_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_flag) |-> !$past(fault_n));

    assert_flag_only_guarded_R9: assert property (@(posedge clk) disable iff (rst)
        fault_flag |-> guard_mode);

    assert_pause_holds_R12: assert property (@(posedge clk) disable iff (rst)
        (hold && !ctrl_wr && !(guard_mode && !fault_n)) |=> $stable(cmp_out));

    assert_alias_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'd0) |-> (bus_rdata == '0));

endmodule

bind ocmp_unit ocmp_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .unit_on    (unit_on),
    .hold       (hold),
    .guard_mode (guard_mode),
    .ctrl_wr    (ctrl_wr),
    .fault_n    (fault_n),
    .cmp_out    (cmp_out),
    .fault_flag (fault_flag),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/ocmp_unit_tb.sv
`timescale 1ns/1ps
module ocmp_unit_tb;

    localparam int    HALF_NS = 10;
    localparam int    WDOG_CYC = 150000;
    localparam [15:0] PARK = 16'h7777;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tmr_a_count = PARK;
    logic        tmr_a_period = 1'b0;
    logic [15:0] tmr_b_count = PARK;
    logic        tmr_b_period = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        idle_req = 1'b0;
    logic        fault_n = 1'b1;
    logic        cmp_out;

    int n_vec = 0;
    int n_bad = 0;

    always #HALF_NS clk = ~clk;

    ocmp_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tmr_a_count  (tmr_a_count),
        .tmr_a_period (tmr_a_period),
        .tmr_b_count  (tmr_b_count),
        .tmr_b_period (tmr_b_period),
        .dbg_halt     (dbg_halt),
        .idle_req     (idle_req),
        .fault_n      (fault_n),
        .cmp_out      (cmp_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks begin and end just after a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 4'd0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_addr = 4'd0;
    endtask

    task automatic tick(input logic [15:0] a, input logic [15:0] b,
                        input logic wa, input logic wb,
                        input string req, input logic exp);
        tmr_a_count  = a;
        tmr_b_count  = b;
        tmr_a_period = wa;
        tmr_b_period = wb;
        @(negedge clk);
        chk(req, {31'd0, cmp_out}, {31'd0, exp});
        tmr_a_count  = PARK;
        tmr_b_count  = PARK;
        tmr_a_period = 1'b0;
        tmr_b_period = 1'b0;
    endtask

    task automatic out_chk(input string req, input logic exp);
        chk(req, {31'd0, cmp_out}, {31'd0, exp});
    endtask

    task automatic t_reset;
        rd_chk(4'h0, 32'h0, "R1 ctrl");
        rd_chk(4'h4, 32'h0, "R1 primary");
        rd_chk(4'h8, 32'h0, "R1 secondary");
        out_chk("R1 output", 1'b0);
    endtask

    task automatic t_alias;
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk(4'h0, 32'h0000_E02F, "R2 ctrl write mask");
        wr(4'h1, 32'h0000_2003);
        rd_chk(4'h0, 32'h0000_C02C, "R2 ctrl clear");
        wr(4'h2, 32'h0000_0010);
        rd_chk(4'h0, 32'h0000_C02C, "R2 ctrl bit4 not writable");
        wr(4'h3, 32'h0000_8008);
        rd_chk(4'h0, 32'h0000_4024, "R2 ctrl invert");
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h1234_5678);
        wr(4'h5, 32'h0000_00F0);
        rd_chk(4'h4, 32'h1234_5608, "R2 primary clear");
        wr(4'h6, 32'hF000_0000);
        rd_chk(4'h4, 32'hF234_5608, "R2 primary set");
        wr(4'h7, 32'h0000_000F);
        rd_chk(4'h4, 32'hF234_5607, "R2 primary invert");
        wr(4'h8, 32'hAAAA_0000);
        wr(4'hA, 32'h0000_5555);
        rd_chk(4'h8, 32'hAAAA_5555, "R2 secondary set");
        rd_chk(4'h5, 32'h0, "R3 primary alias read");
        rd_chk(4'h1, 32'h0, "R3 ctrl alias read");
        rd_chk(4'hB, 32'h0, "R3 secondary alias read");
        rd_chk(4'hC, 32'h0, "R3 unmapped read");
    endtask

    task automatic t_edges;
        wr(4'h4, 32'h0000_0100);
        wr(4'h0, 32'h0000_8001);
        out_chk("R4 mode1 starts low", 1'b0);
        tick(16'h00FF, PARK, 0, 0, "R4 mode1 no match", 1'b0);
        tick(16'h0100, PARK, 0, 0, "R4 mode1 match high", 1'b1);
        tick(16'h0101, PARK, 0, 0, "R4 mode1 stays high", 1'b1);
        wr(4'h0, 32'h0000_8002);
        out_chk("R4 mode2 starts high", 1'b1);
        tick(16'h0100, PARK, 0, 0, "R4 mode2 match low", 1'b0);
        wr(4'h0, 32'h0000_8003);
        out_chk("R4 mode3 starts low", 1'b0);
        tick(16'h0100, PARK, 0, 0, "R4 toggle first", 1'b1);
        tick(16'h0101, PARK, 0, 0, "R4 toggle idle", 1'b1);
        tick(16'h0100, PARK, 0, 0, "R4 toggle second", 1'b0);
    endtask

    task automatic t_pulses;
        wr(4'h4, 32'h0000_0010);
        wr(4'h8, 32'h0000_0020);
        wr(4'h0, 32'h0000_8004);
        tick(16'h0010, PARK, 0, 0, "R5 pulse rises", 1'b1);
        tick(16'h0015, PARK, 0, 0, "R5 pulse holds", 1'b1);
        tick(16'h0020, PARK, 0, 0, "R5 pulse falls", 1'b0);
        tick(16'h0010, PARK, 0, 0, "R5 single pulse done", 1'b0);
        wr(4'h0, 32'h0000_8005);
        tick(16'h0010, PARK, 0, 0, "R6 first pulse", 1'b1);
        tick(16'h0020, PARK, 0, 0, "R6 first pulse ends", 1'b0);
        tick(16'h0010, PARK, 0, 0, "R6 pulse repeats", 1'b1);
    endtask

    task automatic t_pwm;
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h0000_0040);
        wr(4'h0, 32'h0000_8006);
        tick(16'h0000, PARK, 1, 0, "R7 period strobe high", 1'b1);
        rd_chk(4'h4, 32'h0000_0040, "R7 duty copied");
        tick(16'h003F, PARK, 0, 0, "R7 before duty", 1'b1);
        tick(16'h0040, PARK, 0, 0, "R7 duty match low", 1'b0);
        tick(16'h0041, PARK, 0, 0, "R7 stays low", 1'b0);
        wr(4'h8, 32'h0000_0010);
        rd_chk(4'h4, 32'h0000_0040, "R7 primary until strobe");
        tick(16'h0000, PARK, 1, 0, "R7 new period", 1'b1);
        rd_chk(4'h4, 32'h0000_0010, "R7 new duty copied");
        tick(16'h0010, PARK, 0, 0, "R7 new duty low", 1'b0);
        wr(4'h0, 32'h0000_8006);
        tick(16'h0000, PARK, 1, 0, "R9 mode6 high", 1'b1);
        fault_n = 1'b0;
        tick(16'h0005, PARK, 0, 0, "R9 fault ignored", 1'b1);
        rd_chk(4'h0, 32'h0000_8006, "R9 flag stays clear");
        fault_n = 1'b1;
    endtask

    task automatic t_fault;
        wr(4'h8, 32'h0000_0040);
        wr(4'h0, 32'h0000_8007);
        tick(16'h0000, PARK, 1, 0, "R8 guarded pwm high", 1'b1);
        fault_n = 1'b0;
        tick(16'h0005, PARK, 0, 0, "R8 fault forces low", 1'b0);
        rd_chk(4'h0, 32'h0000_8017, "R8 flag set");
        fault_n = 1'b1;
        tick(16'h0000, PARK, 1, 0, "R8 latched low", 1'b0);
        wr(4'h0, 32'h0000_8007);
        rd_chk(4'h0, 32'h0000_8007, "R8 flag cleared");
        tick(16'h0000, PARK, 1, 0, "R8 resumes", 1'b1);
    endtask

    task automatic t_off;
        wr(4'h4, 32'h0000_0100);
        wr(4'h0, 32'h0000_0003);
        tick(16'h0100, PARK, 0, 0, "R10 disabled ignores match", 1'b0);
        wr(4'h0, 32'h0000_8000);
        tick(16'h0100, PARK, 0, 0, "R10 mode0 low", 1'b0);
    endtask

    task automatic t_select;
        wr(4'h4, 32'h0000_0055);
        wr(4'h0, 32'h0000_800B);
        tick(16'h0055, 16'h0000, 0, 0, "R11 timer A not selected", 1'b0);
        tick(16'h0000, 16'h0055, 0, 0, "R11 timer B match", 1'b1);
        wr(4'h4, 32'h0003_0055);
        wr(4'h0, 32'h0000_8023);
        tick(16'h0055, 16'h0000, 0, 0, "R11 wide high half differs", 1'b0);
        tick(16'h0055, 16'h0003, 0, 0, "R11 wide full match", 1'b1);
    endtask

    task automatic t_pause;
        wr(4'h4, 32'h0000_0100);
        wr(4'h0, 32'h0000_C003);
        dbg_halt = 1'b1;
        tick(16'h0100, PARK, 0, 0, "R12 frozen", 1'b0);
        dbg_halt = 1'b0;
        tick(16'h0100, PARK, 0, 0, "R12 unfrozen", 1'b1);
        wr(4'h0, 32'h0000_A003);
        idle_req = 1'b1;
        tick(16'h0100, PARK, 0, 0, "R12 idle stop", 1'b0);
        idle_req = 1'b0;
        tick(16'h0100, PARK, 0, 0, "R12 idle released", 1'b1);
        wr(4'h0, 32'h0000_8003);
        dbg_halt = 1'b1;
        idle_req = 1'b1;
        tick(16'h0100, PARK, 0, 0, "R12 requests without enables", 1'b1);
        dbg_halt = 1'b0;
        idle_req = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alias();
        t_edges();
        t_pulses();
        t_pwm();
        t_fault();
        t_off();
        t_select();
        t_pause();
        summary();
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule